// File: doc/BRIEF.md
# Single-Channel Terminal Register Controller

This block sits between a simple request/response bus and one character stream toward a serializer. The host sees four word registers. Index 0 takes a character to transmit. Index 1 reports receive status. Index 2 returns the received character. Index 3 holds the receive interrupt enable. Received characters enter through a valid-qualified byte port. Transmitted characters leave through a valid/ready byte port.

Transmit flow control has no status bit and no interrupt. A host write to the transmit register is accepted, but its response is held back while the previous character is still waiting for the downstream handshake. Software can therefore stream characters with plain writes and is paced by the bus. The receive side keeps one character. It raises a level interrupt while that character is unread and the enable is set. A character that arrives while the register is still full is discarded and recorded in a sticky overrun flag.

Top module: `term_ctrl`

## Requirements
- R1: The word index `req_addr` selects the register: 0 is transmit data, 1 is status, 2 is receive data and 3 is configuration. A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. Unless it is stalled (R8), `rsp_valid` is 1 for exactly the one cycle that follows acceptance, and `rsp_rdata` carries the read data in that cycle.
- R2: While reset is applied and after it is released, `tx_valid` is 0 and `rx_irq` is 0. Status (index 1) reads 0 and configuration (index 3) reads 0.
- R3: When `rx_valid` is 1 and status bit 0 is 0, `rx_data` is stored and status bit 0 becomes 1.
- R4: A read of index 2 returns the stored byte in bits 7:0, with bits 31:8 at 0. Status bit 0 clears at the end of that response cycle.
- R5: A character that arrives while status bit 0 is 1 is dropped. This includes the cycle in which the clearing read response is issued. The dropped character leaves the stored byte unchanged and sets status bit 1. Status bit 1 clears at the end of a status read response, and that read still reports it as 1.
- R6: `rx_irq` is 1 exactly when status bit 0 and configuration bit 0 are both 1.
- R7: A write to index 0 makes bits 7:0 of the write data appear on `tx_data` with `tx_valid` at 1. Both stay unchanged until a cycle in which `tx_ready` is 1.
- R8: A write to index 0 issued while a previous character is still waiting gets no response until that character's handshake completes. The new character is then taken and the response follows.
- R9: Unused bits read 0. Index 0 reads 0, status bits 31:2 read 0, and configuration bits 31:1 read 0. The block has no transmit status bit.
- R10: Writes to index 1 and index 2 receive a normal response and change no state.
- R11: Only one request is outstanding at a time. `req_ready` is 0 from the cycle after acceptance until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this edge when both are high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| rx_valid | input | 1 | Incoming character strobe |
| rx_data | input | 8 | Incoming character |
| tx_valid | output | 1 | Outgoing character present |
| tx_ready | input | 1 | Downstream accepts the character |
| tx_data | output | 8 | Outgoing character |
| rx_irq | output | 1 | Receive interrupt (level) |

## Verification
The hardest state to reach is a transmit write that is parked inside the block. The previous character must be stalled downstream while a second write is already accepted. The bench holds `tx_ready` low, issues one write, and then issues a second write in parallel with a thread that keeps the sink stalled for several cycles. That thread checks for no response and an unchanged `tx_data`, then releases a single handshake cycle, and the bench checks the exact response latency. Overrun is reached by sending a second character before reading the first. Both data paths are swept over all 256 byte values.

// File: rtl/term_pkg.sv
package term_pkg;
  localparam int TERM_ADDR_W = 2;

  localparam logic [TERM_ADDR_W-1:0] IDX_TXD  = 2'd0;
  localparam logic [TERM_ADDR_W-1:0] IDX_STAT = 2'd1;
  localparam logic [TERM_ADDR_W-1:0] IDX_RXD  = 2'd2;
  localparam logic [TERM_ADDR_W-1:0] IDX_CFG  = 2'd3;

  localparam int STAT_FULL_POS = 0;
  localparam int STAT_OVR_POS  = 1;
  localparam int CFG_RXEN_POS  = 0;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_WAIT = 2'd1,
    BS_RESP = 2'd2
  } bus_state_e;
endpackage

// File: rtl/term_rst_sync.sv
module term_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/term_bus_slave.sv
module term_bus_slave
  import term_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = TERM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              tx_busy,
  output logic              rsp_valid,
  output logic              op_we,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_wdata
);
  bus_state_e        state_q, state_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en;
  logic              is_tx_write;

  assign req_ready   = (state_q == BS_IDLE);
  assign cap_en      = req_valid && req_ready;
  assign is_tx_write = req_we && (req_addr == IDX_TXD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_IDLE: if (req_valid) state_d = (is_tx_write && tx_busy) ? BS_WAIT : BS_RESP;
      BS_WAIT: if (!tx_busy)  state_d = BS_RESP;
      BS_RESP:                state_d = BS_IDLE;
      default:                state_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        we_q    <= req_we;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign rsp_valid = (state_q == BS_RESP);
  assign op_we     = we_q;
  assign op_addr   = addr_q;
  assign op_wdata  = wdata_q;
endmodule

// File: rtl/term_tx_holder.sv
module term_tx_holder #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_data,
  output logic              busy,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data
);
  logic              full_q, full_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              drain;

  assign drain = full_q && tx_ready;

  always_comb begin
    full_d = full_q;
    data_d = data_q;
    if (load) begin
      full_d = 1'b1;
      data_d = load_data;
    end else if (drain) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign busy     = full_q;
  assign tx_valid = full_q;
  assign tx_data  = data_q;
endmodule

// File: rtl/term_rx_holder.sv
module term_rx_holder #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic              full,
  output logic              ovr,
  output logic [CHAR_W-1:0] held
);
  logic              full_q, full_d;
  logic              ovr_q, ovr_d;
  logic [CHAR_W-1:0] held_q, held_d;
  logic              take, drop;

  assign take = rx_valid && !full_q;
  assign drop = rx_valid && full_q;

  always_comb begin
    full_d = full_q;
    held_d = held_q;
    ovr_d  = ovr_q;
    if (take) begin
      full_d = 1'b1;
      held_d = rx_data;
    end else if (data_rd) begin
      full_d = 1'b0;
    end
    if (drop)         ovr_d = 1'b1;
    else if (stat_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      held_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      held_q <= held_d;
    end
  end

  assign full = full_q;
  assign ovr  = ovr_q;
  assign held = held_q;
endmodule

// File: rtl/term_ctrl.sv
module term_ctrl
  import term_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CHAR_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic              rx_irq
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic                   srst_n;
  logic                   op_we;
  logic [TERM_ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0]      op_wdata;
  logic                   tx_busy;
  logic                   tx_load;
  logic                   rx_full, rx_ovr;
  logic [CHAR_W-1:0]      rx_byte;
  logic                   rd_rxd, rd_stat;
  logic                   cfg_en_q, cfg_en_d;
  logic [DATA_W-1:0]      rd_mux;
  logic                   unused_wdata_bits;

  term_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  term_bus_slave #(.DATA_W(DATA_W), .ADDR_W(TERM_ADDR_W)) u_bus (
    .clk(clk), .rst_n(srst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .tx_busy(tx_busy),
    .rsp_valid(rsp_valid), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata)
  );

  assign tx_load = rsp_valid && op_we && (op_addr == IDX_TXD);
  assign rd_rxd  = rsp_valid && !op_we && (op_addr == IDX_RXD);
  assign rd_stat = rsp_valid && !op_we && (op_addr == IDX_STAT);

  term_tx_holder #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(srst_n), .load(tx_load), .load_data(op_wdata[CHAR_W-1:0]),
    .busy(tx_busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  term_rx_holder #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(srst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .data_rd(rd_rxd), .stat_rd(rd_stat),
    .full(rx_full), .ovr(rx_ovr), .held(rx_byte)
  );

  always_comb begin
    cfg_en_d = cfg_en_q;
    if (rsp_valid && op_we && (op_addr == IDX_CFG)) cfg_en_d = op_wdata[CFG_RXEN_POS];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cfg_en_q <= 1'b0;
    else         cfg_en_q <= cfg_en_d;
  end

  always_comb begin
    rd_mux = '0;
    unique case (op_addr)
      IDX_STAT: begin
        rd_mux[STAT_FULL_POS] = rx_full;
        rd_mux[STAT_OVR_POS]  = rx_ovr;
      end
      IDX_RXD:  rd_mux = {{PAD_W{1'b0}}, rx_byte};
      IDX_CFG:  rd_mux[CFG_RXEN_POS] = cfg_en_q;
      default:  rd_mux = '0;
    endcase
  end

  assign rsp_rdata = (rsp_valid && !op_we) ? rd_mux : '0;
  assign rx_irq    = rx_full & cfg_en_q;

  assign unused_wdata_bits = ^op_wdata[DATA_W-1:CHAR_W];
endmodule

// File: rtl/term_ctrl_chk.sv
module term_ctrl_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [1:0]        req_addr,
  input logic              rsp_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [CHAR_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_full,
  input logic              rx_ovr,
  input logic [CHAR_W-1:0] rx_byte,
  input logic              rx_irq
);
  logic last_rd_rx_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) last_rd_rx_q <= 1'b0;
    else if (req_valid && req_ready) last_rd_rx_q <= !req_we && (req_addr == 2'd2);
  end

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_then_idle_r1: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_tx_stall_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && req_ready && req_we && req_addr == 2'd0 && tx_valid && !tx_ready)
      |=> !rsp_valid);

  p_overrun_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_valid && rx_full) |=> (rx_ovr && $stable(rx_byte)));

  p_irq_drop_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && last_rd_rx_q) |=> !rx_irq);
endmodule

bind term_ctrl term_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .srst_n(srst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_byte(rx_byte),
  .rx_irq(rx_irq)
);

// File: tb/tb_term_ctrl.sv
`timescale 1ns/1ps
module tb_term_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_valid, tx_ready;
  logic [7:0]  tx_data;
  logic        rx_irq;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] seen [0:511];
  int seen_n = 0;

  always #2 clk = ~clk;

  term_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    #1;
    if (tx_valid && tx_ready && seen_n < 512) begin
      seen[seen_n] = tx_data;
      seen_n++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [1:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    check(req_ready == 1'b0, "R11 busy after accept", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] rd);
    int lat;
    bus_op(1'b0, a, 32'h0, rd, lat);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] wd);
    logic [31:0] d;
    int lat;
    bus_op(1'b1, a, wd, d, lat);
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = 2'd0; req_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(tx_valid == 1'b0 && rx_irq == 1'b0, "R2 outputs in reset",
          {30'b0, tx_valid, rx_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset register values, R1 latency
    bus_op(1'b0, 2'd1, 32'h0, d, lat);
    check(d == 32'h0, "R2 status after reset", d, 32'h0);
    check(lat == 1, "R1 response latency", lat, 32'd1);
    rd_reg(2'd3, d);
    check(d == 32'h0, "R2 config after reset", d, 32'h0);
    check(tx_valid == 1'b0, "R2 tx idle after reset", {31'b0, tx_valid}, 32'h0);

    // R3 R4 sweep of all receive bytes
    for (int i = 0; i < 256; i++) begin
      rx_push(i[7:0]);
      rd_reg(2'd1, d);
      check(d == 32'h1, "R3 full after arrival", d, 32'h1);
      rd_reg(2'd2, d);
      check(d == {24'h0, i[7:0]}, "R4 rx data", d, {24'h0, i[7:0]});
      rd_reg(2'd1, d);
      check(d == 32'h0, "R4 full cleared by read", d, 32'h0);
    end

    // R5 overrun
    rx_push(8'h11);
    rx_push(8'h22);
    rd_reg(2'd1, d);
    check(d == 32'h3, "R5 overrun reported", d, 32'h3);
    rd_reg(2'd1, d);
    check(d == 32'h1, "R5 overrun cleared by status read", d, 32'h1);
    rd_reg(2'd2, d);
    check(d == 32'h11, "R5 first byte kept", d, 32'h11);
    // R5 arrival during clearing read response is dropped
    rx_push(8'h33);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 2'd2;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rx_valid = 1'b1; rx_data = 8'h44;
    d = rsp_rdata;
    @(negedge clk);
    rx_valid = 1'b0;
    check(d == 32'h33, "R5 read in drop cycle", d, 32'h33);
    rd_reg(2'd1, d);
    check(d == 32'h2, "R5 drop during clearing read", d, 32'h2);

    // R6 interrupt gating
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd3, d);
    check(d == 32'h1, "R9 config reads bit0 only", d, 32'h1);
    check(rx_irq == 1'b0, "R6 irq low when empty", {31'b0, rx_irq}, 32'h0);
    rx_push(8'h5A);
    check(rx_irq == 1'b1, "R6 irq when full and enabled", {31'b0, rx_irq}, 32'h1);
    wr_reg(2'd3, 32'h0);
    check(rx_irq == 1'b0, "R6 irq masked", {31'b0, rx_irq}, 32'h0);
    wr_reg(2'd3, 32'h1);
    check(rx_irq == 1'b1, "R6 irq re-enabled", {31'b0, rx_irq}, 32'h1);

    // R10 writes to read-only registers
    wr_reg(2'd1, 32'hFFFF_FFFF);
    wr_reg(2'd2, 32'h0000_0000);
    rd_reg(2'd1, d);
    check(d == 32'h1, "R10 status unchanged", d, 32'h1);
    check(rx_irq == 1'b1, "R10 irq unchanged", {31'b0, rx_irq}, 32'h1);
    rd_reg(2'd2, d);
    check(d == 32'h5A, "R10 rx data unchanged", d, 32'h5A);
    check(rx_irq == 1'b0, "R6 irq drops after read", {31'b0, rx_irq}, 32'h0);
    wr_reg(2'd3, 32'h0);

    // R7 R8 transmit stall
    tx_ready = 1'b0;
    bus_op(1'b1, 2'd0, 32'hFFFF_FFA1, d, lat);
    check(lat == 1, "R8 free write latency", lat, 32'd1);
    check(tx_valid && tx_data == 8'hA1, "R7 tx presented", {23'b0, tx_valid, tx_data},
          {23'b0, 1'b1, 8'hA1});
    rd_reg(2'd0, d);
    check(d == 32'h0, "R9 index 0 reads zero", d, 32'h0);
    rd_reg(2'd1, d);
    check(d == 32'h0, "R9 no transmit status", d, 32'h0);
    seen_n = 0;
    fork
      bus_op(1'b1, 2'd0, 32'h0000_00B2, d, lat);
      begin
        repeat (5) begin
          @(negedge clk);
          check(!rsp_valid && tx_valid && tx_data == 8'hA1, "R8 held while stalled",
                {22'b0, rsp_valid, tx_valid, tx_data}, {23'b0, 1'b1, 8'hA1});
        end
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
      end
    join
    check(lat == 7, "R8 stalled write latency", lat, 32'd7);
    check(tx_valid && tx_data == 8'hB2, "R8 new byte after drain",
          {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'hB2});
    check(seen_n == 1 && seen[0] == 8'hA1, "R7 single handshake of first byte",
          {24'b0, seen[0]}, 32'hA1);

    // R7 sweep of all transmit bytes with sink ready
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    seen_n = 0;
    for (int i = 0; i < 256; i++) wr_reg(2'd0, {24'hC3D2E1, i[7:0]});
    repeat (4) @(negedge clk);
    check(seen_n == 256, "R7 sweep count", seen_n, 32'd256);
    for (int i = 0; i < 256; i++)
      check(seen[i] == i[7:0], "R7 sweep byte", {24'b0, seen[i]}, {24'b0, i[7:0]});
    check(tx_valid == 1'b0, "R7 idle after drain", {31'b0, tx_valid}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule